// File: doc/BRIEF.md
# MDIO Management Slave with Bit-Bang Host Port

This block models a clause-22-style serial management target together with the software-visible bit-bang port that drives it. A host writes a small control register. One bit sets the management clock level, one bit sets the data level the host puts out, and one bit lets the host drive the data line at all. A status output returns the level the data line has at that moment. When nobody drives the line it is pulled high.

Inside the block a frame decoder watches the management clock through these control writes. Every control write that changes the clock level counts as one edge, so each bit period is two edges. After a long enough run of idle edges the decoder takes in the start bits, a 2-bit operation code, a 5-bit device address and a 5-bit register number. It then lets two turnaround bits pass and moves 16 data bits. Reads fetch a word from the attached device's register port and shift it out on the line. Writes collect a word and commit it to that port. Only one device is attached, at the address on a configuration input. A read aimed at any other address is answered with all ones.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, the clock, host output and host enable outputs are 0, the slave does not drive the line, the status reads 1 (pulled high), and the decoder waits for an idle run.
- R2: A control write sets the clock output from bit 2, the host output enable from bit 1 and the host data output from bit 0. The status then reads bit 0 when bit 1 is set and 1 otherwise.
- R3: A start bit (0 sampled on a rising clock edge) is accepted only if at least 32 full idle bit periods (64 clock edges) preceded it. After a shorter idle run that frame's data commits no write.
- R4: A write frame (operation code 01) addressed to the configured device pulses `phy_wr_o` for one cycle after the rising edge of the 16th data bit. The pulse carries the register number sent and the 16 data bits, taken MSB first.
- R5: A write frame addressed to any other device address is discarded: there is no write pulse and the slave never drives the line.
- R6: A read frame (operation code 10) to the configured device pulses `phy_rd_o` once at the end of the turnaround. The slave then drives the stored word MSB first, and each new bit appears on the line after a falling clock edge.
- R7: A read frame to an unattached address makes no `phy_rd_o` pulse, and the slave drives 16 ones.
- R8: After the rising edge of the 16th data bit the slave releases the line and the decoder returns to the idle-count state. A following frame with a full idle run is decoded normally.
- R9: Control writes that leave the clock level unchanged do not advance the decoder, even if they change the data line.
- R10: Operation codes 00 and 11 cause neither a register read nor a write, and the slave never drives the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control value: bit 2 clock level, bit 1 host drive enable, bit 0 host data |
| cfg_phy_addr_i | input | 5 | Device address of the attached register port |
| mdc_o | output | 1 | Management clock level from the control register |
| mdio_out_o | output | 1 | Host data output value |
| mdio_oe_o | output | 1 | Host data output enable |
| stat_mdio_o | output | 1 | Current data line level (status register bit 0) |
| slave_oe_o | output | 1 | Slave is driving the data line |
| phy_reg_o | output | 5 | Register number of the current frame |
| phy_rd_o | output | 1 | One-cycle read strobe to the attached device |
| phy_rd_data_i | input | 16 | Read data from the attached device for `phy_reg_o` |
| phy_wr_o | output | 1 | One-cycle write commit strobe |
| phy_wr_data_o | output | 16 | Data committed with `phy_wr_o` |

## Verification
Directed frames cover several cases. A write then a read to the same register shows that the commit and the serial readback use the same bit order. Reads and writes to a foreign address tell the all-ones answer apart from a silent discard. The two unused operation codes show that only 01 and 10 act. A frame that follows a 31-bit idle run shows that the idle threshold is real. Random frames mix matched and foreign addresses, random registers and data, and random extra control writes that keep the clock level. A decoder that counts writes instead of clock changes would then misplace bits, and that shows up in the read data or the commit values.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   typedef enum logic [2:0] {
      DS_IDLE,
      DS_START,
      DS_OPC,
      DS_PHYAD,
      DS_REGAD,
      DS_TURN,
      DS_DATA
   } dec_st_t;

   localparam logic [1:0] OPC_WR = 2'b01;
   localparam logic [1:0] OPC_RD = 2'b10;
   localparam int         OPC_W       = 2;
   localparam int         START_EDGES = 2;
   localparam int         TURN_EDGES  = 4;

endpackage

// File: rtl/mdio_host_port.sv
module mdio_host_port (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [2:0] ctl_wdata,
   output logic       mdc_q,
   output logic       out_q,
   output logic       oe_q,
   output logic       edge_ev,
   output logic       rise,
   output logic       eff_oe,
   output logic       eff_out
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
         out_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (ctl_we) begin
         mdc_q <= ctl_wdata[2];
         oe_q  <= ctl_wdata[1];
         out_q <= ctl_wdata[0];
      end
   end

   // An edge is a control write that flips the clock level.
   assign edge_ev = ctl_we && (ctl_wdata[2] != mdc_q);
   assign rise    = ctl_wdata[2];
   // Host drive as it stands after the write in progress.
   assign eff_oe  = ctl_we ? ctl_wdata[1] : oe_q;
   assign eff_out = ctl_we ? ctl_wdata[0] : out_q;

   a_r2_mdc_follows: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (mdc_q == $past(ctl_wdata[2])))
      else $error("R2: clock level does not follow control write");

endmodule

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec
   import mdio_slv_pkg::*;
#(
   parameter int PHY_AW        = 5,
   parameter int REG_AW        = 5,
   parameter int DATA_W        = 16,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edge_ev,
   input  logic              rise,
   input  logic              line_smp,
   input  logic [PHY_AW-1:0] phy_addr_cfg,
   input  logic [DATA_W-1:0] phy_rd_data,
   output logic              slave_oe,
   output logic              slave_bit,
   output logic [REG_AW-1:0] phy_reg,
   output logic              phy_rd,
   output logic              phy_wr,
   output logic [DATA_W-1:0] phy_wr_data
);

   localparam int PRE_EDGES = 2 * PREAMBLE_BITS;
   localparam int MAX_CNT   = (PRE_EDGES + 1 > 2 * DATA_W) ? PRE_EDGES + 1 : 2 * DATA_W;
   localparam int CNT_W     = $clog2(MAX_CNT + 1);

   localparam logic [CNT_W-1:0] C_PRE_SAT = CNT_W'(PRE_EDGES + 1);
   localparam logic [CNT_W-1:0] C_START   = CNT_W'(START_EDGES);
   localparam logic [CNT_W-1:0] C_OPC     = CNT_W'(2 * OPC_W);
   localparam logic [CNT_W-1:0] C_PHYAD   = CNT_W'(2 * PHY_AW);
   localparam logic [CNT_W-1:0] C_REGAD   = CNT_W'(2 * REG_AW);
   localparam logic [CNT_W-1:0] C_TURN    = CNT_W'(TURN_EDGES);
   localparam logic [CNT_W-1:0] C_DATA    = CNT_W'(2 * DATA_W);

   generate
      if (DATA_W < 2)        begin : g_bad_dw  $error("DATA_W must be at least 2"); end
      if (PHY_AW < 1)        begin : g_bad_paw $error("PHY_AW must be at least 1"); end
      if (REG_AW < 1)        begin : g_bad_raw $error("REG_AW must be at least 1"); end
      if (PREAMBLE_BITS < 1) begin : g_bad_pre $error("PREAMBLE_BITS must be at least 1"); end
   endgenerate

   dec_st_t           st;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_nx;
   logic [OPC_W-1:0]  opc;
   logic [PHY_AW-1:0] pad;
   logic [DATA_W-1:0] dat;
   logic              addr_hit;

   assign cnt_nx   = cnt + 1'b1;
   assign addr_hit = (pad == phy_addr_cfg);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= DS_IDLE;
         cnt         <= '0;
         opc         <= '0;
         pad         <= '0;
         phy_reg     <= '0;
         dat         <= '0;
         slave_oe    <= 1'b0;
         slave_bit   <= 1'b1;
         phy_rd      <= 1'b0;
         phy_wr      <= 1'b0;
         phy_wr_data <= '0;
      end else begin
         phy_rd <= 1'b0;
         phy_wr <= 1'b0;
         if (edge_ev) begin
            unique case (st)
               DS_IDLE: begin
                  if (rise && cnt == C_PRE_SAT && !line_smp) begin
                     st  <= DS_START;
                     cnt <= '0;
                  end else if (cnt != C_PRE_SAT) begin
                     cnt <= cnt_nx;
                  end
               end
               DS_START: begin
                  cnt <= cnt_nx;
                  if (rise && cnt_nx == C_START) begin
                     st  <= DS_OPC;
                     cnt <= '0;
                  end
               end
               DS_OPC: begin
                  cnt <= cnt_nx;
                  if (rise) opc <= {opc[OPC_W-2:0], line_smp};
                  if (rise && cnt_nx == C_OPC) begin
                     st  <= DS_PHYAD;
                     cnt <= '0;
                  end
               end
               DS_PHYAD: begin
                  cnt <= cnt_nx;
                  if (rise) pad <= (pad << 1) | PHY_AW'(line_smp);
                  if (rise && cnt_nx == C_PHYAD) begin
                     st  <= DS_REGAD;
                     cnt <= '0;
                  end
               end
               DS_REGAD: begin
                  cnt <= cnt_nx;
                  if (rise) phy_reg <= (phy_reg << 1) | REG_AW'(line_smp);
                  if (rise && cnt_nx == C_REGAD) begin
                     st  <= DS_TURN;
                     cnt <= '0;
                  end
               end
               DS_TURN: begin
                  cnt <= cnt_nx;
                  if (rise && cnt_nx == C_TURN) begin
                     st  <= DS_DATA;
                     cnt <= '0;
                     if (opc == OPC_RD) begin
                        slave_oe  <= 1'b1;
                        slave_bit <= 1'b0;
                        if (addr_hit) begin
                           dat    <= phy_rd_data;
                           phy_rd <= 1'b1;
                        end else begin
                           dat <= '1;
                        end
                     end
                  end
               end
               DS_DATA: begin
                  cnt <= cnt_nx;
                  if (!rise && slave_oe) begin
                     slave_bit <= dat[DATA_W-1];
                     dat       <= {dat[DATA_W-2:0], 1'b0};
                  end
                  if (rise && !slave_oe) dat <= {dat[DATA_W-2:0], line_smp};
                  if (rise && cnt_nx == C_DATA) begin
                     st        <= DS_IDLE;
                     cnt       <= '0;
                     slave_oe  <= 1'b0;
                     slave_bit <= 1'b1;
                     if (!slave_oe && opc == OPC_WR && addr_hit) begin
                        phy_wr      <= 1'b1;
                        phy_wr_data <= {dat[DATA_W-2:0], line_smp};
                     end
                  end
               end
               default: st <= DS_IDLE;
            endcase
         end
      end
   end

   a_r6_drive_only_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      slave_oe |-> (st == DS_DATA))
      else $error("R6: slave drives outside the data phase");

   a_r9_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !edge_ev |=> ($stable(st) && $stable(cnt)))
      else $error("R9: decoder moved without a clock change");

   a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      phy_wr |=> !phy_wr)
      else $error("R4: write strobe longer than one cycle");

   a_r7_read_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      phy_rd |-> addr_hit)
      else $error("R7: read strobe for a foreign address");

   a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (st == DS_IDLE && $past(st) == DS_DATA) |-> !slave_oe)
      else $error("R8: line not released after data phase");

   a_r10_no_strobe_odd_opc: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_wr || phy_rd) |-> (opc == OPC_WR || opc == OPC_RD))
      else $error("R10: strobe for an unused operation code");

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
   parameter int PHY_AW        = 5,
   parameter int REG_AW        = 5,
   parameter int DATA_W        = 16,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we_i,
   input  logic [2:0]        ctl_wdata_i,
   input  logic [PHY_AW-1:0] cfg_phy_addr_i,
   output logic              mdc_o,
   output logic              mdio_out_o,
   output logic              mdio_oe_o,
   output logic              stat_mdio_o,
   output logic              slave_oe_o,
   output logic [REG_AW-1:0] phy_reg_o,
   output logic              phy_rd_o,
   input  logic [DATA_W-1:0] phy_rd_data_i,
   output logic              phy_wr_o,
   output logic [DATA_W-1:0] phy_wr_data_o
);

   logic edge_ev, rise, eff_oe, eff_out;
   logic slave_bit, line_smp;

   mdio_host_port u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ctl_we_i),
      .ctl_wdata (ctl_wdata_i),
      .mdc_q     (mdc_o),
      .out_q     (mdio_out_o),
      .oe_q      (mdio_oe_o),
      .edge_ev   (edge_ev),
      .rise      (rise),
      .eff_oe    (eff_oe),
      .eff_out   (eff_out)
   );

   // Wired line: slave wins, then host, otherwise pulled high.
   assign line_smp    = slave_oe_o ? slave_bit : (eff_oe ? eff_out : 1'b1);
   assign stat_mdio_o = slave_oe_o ? slave_bit : (mdio_oe_o ? mdio_out_o : 1'b1);

   mdio_frame_dec #(
      .PHY_AW        (PHY_AW),
      .REG_AW        (REG_AW),
      .DATA_W        (DATA_W),
      .PREAMBLE_BITS (PREAMBLE_BITS)
   ) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .edge_ev      (edge_ev),
      .rise         (rise),
      .line_smp     (line_smp),
      .phy_addr_cfg (cfg_phy_addr_i),
      .phy_rd_data  (phy_rd_data_i),
      .slave_oe     (slave_oe_o),
      .slave_bit    (slave_bit),
      .phy_reg      (phy_reg_o),
      .phy_rd       (phy_rd_o),
      .phy_wr       (phy_wr_o),
      .phy_wr_data  (phy_wr_data_o)
   );

   a_r1_status_pulled_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_oe_o && !mdio_oe_o) |-> stat_mdio_o)
      else $error("R1: undriven line does not read high");

endmodule

// File: tb/sim_mdio_mgmt_slave.sv
module sim_mdio_mgmt_slave;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [2:0]  ctl_wdata = 3'b000;
   logic [4:0]  cfg_addr = 5'd5;
   logic        mdc, mdio_out, mdio_oe, stat, slave_oe, phy_rd, phy_wr;
   logic [4:0]  phy_reg;
   logic [15:0] phy_rd_data, phy_wr_data;

   logic [15:0] dev_mem [32];
   logic [15:0] exp_mem [32];

   int n_cmp = 0;
   int n_bad = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int cyc = 0;
   bit oe_seen = 0;
   logic [4:0]  last_reg;
   logic [15:0] last_data;

   always #4 clk = ~clk;

   assign phy_rd_data = dev_mem[phy_reg];

   mdio_mgmt_slave u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctl_we_i       (ctl_we),
      .ctl_wdata_i    (ctl_wdata),
      .cfg_phy_addr_i (cfg_addr),
      .mdc_o          (mdc),
      .mdio_out_o     (mdio_out),
      .mdio_oe_o      (mdio_oe),
      .stat_mdio_o    (stat),
      .slave_oe_o     (slave_oe),
      .phy_reg_o      (phy_reg),
      .phy_rd_o       (phy_rd),
      .phy_rd_data_i  (phy_rd_data),
      .phy_wr_o       (phy_wr),
      .phy_wr_data_o  (phy_wr_data)
   );

   always @(negedge clk) begin
      if (phy_wr) begin
         wr_cnt++;
         last_reg  = phy_reg;
         last_data = phy_wr_data;
         dev_mem[phy_reg] = phy_wr_data;
      end
      if (phy_rd) rd_cnt++;
      if (slave_oe) oe_seen = 1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL all: watchdog expired act=%0d exp<=150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic ctl_wr(input logic [2:0] v);
      ctl_we = 1'b1;
      ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic bit_out(input logic b, input bit dummies);
      ctl_wr({1'b0, 1'b1, b});
      if (dummies && ($urandom % 3 == 0)) begin
         ctl_wr({1'b0, 1'b1, ~b});
         ctl_wr({1'b0, 1'b0, ~b});
         ctl_wr({1'b0, 1'b1, b});
      end
      ctl_wr({1'b1, 1'b1, b});
   endtask

   task automatic bit_in(output logic b);
      ctl_wr(3'b000);
      b = stat;
      ctl_wr(3'b100);
   endtask

   task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] wd, input bit dm,
                            output logic [15:0] rd);
      logic b;
      rd = '0;
      oe_seen = 0;
      for (int i = 0; i < pre; i++) bit_out(1'b1, dm);
      bit_out(1'b0, dm);
      bit_out(1'b1, dm);
      for (int i = 1; i >= 0; i--) bit_out(op[i], dm);
      for (int i = 4; i >= 0; i--) bit_out(pa[i], dm);
      for (int i = 4; i >= 0; i--) bit_out(ra[i], dm);
      if (op == 2'b10) begin
         bit_in(b);
         bit_in(b);
         for (int i = 15; i >= 0; i--) begin
            bit_in(b);
            rd[i] = b;
         end
      end else begin
         bit_out(1'b1, dm);
         bit_out(1'b0, dm);
         for (int i = 15; i >= 0; i--) bit_out(wd[i], dm);
      end
   endtask

   task automatic do_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd, input bit dm);
      int w0;
      logic [15:0] rd;
      w0 = wr_cnt;
      run_frame(32, 2'b01, pa, ra, wd, dm, rd);
      if (pa == cfg_addr) begin
         chk(wr_cnt == w0 + 1, "R4 write count", wr_cnt, w0 + 1);
         chk(last_reg == ra, "R4 write register", last_reg, ra);
         chk(last_data == wd, dm ? "R9 write data with extra writes" : "R4 write data", last_data, wd);
         exp_mem[ra] = wd;
      end else begin
         chk(wr_cnt == w0, "R5 foreign write discarded", wr_cnt, w0);
         chk(oe_seen == 0, "R5 no drive on foreign write", oe_seen, 0);
      end
   endtask

   task automatic do_read(input logic [4:0] pa, input logic [4:0] ra, input bit dm);
      int r0;
      logic [15:0] rd;
      r0 = rd_cnt;
      run_frame(32, 2'b10, pa, ra, 16'h0, dm, rd);
      if (pa == cfg_addr) begin
         chk(rd_cnt == r0 + 1, "R6 read strobe", rd_cnt, r0 + 1);
         chk(rd == exp_mem[ra], "R6 read data", rd, exp_mem[ra]);
      end else begin
         chk(rd_cnt == r0, "R7 no strobe foreign read", rd_cnt, r0);
         chk(rd == 16'hFFFF, "R7 foreign read all ones", rd, 16'hFFFF);
         chk(oe_seen == 1, "R7 slave answers foreign read", oe_seen, 1);
      end
      chk(slave_oe == 0, "R8 line released after read", slave_oe, 0);
      chk(stat == 1, "R8 line high after read", stat, 1);
   endtask

   initial begin
      logic [15:0] rd;
      int w0, r0;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 32; i++) begin
         dev_mem[i] = 16'($urandom);
         exp_mem[i] = dev_mem[i];
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(mdc == 0 && mdio_oe == 0 && mdio_out == 0, "R1 control outputs", {mdc, mdio_oe, mdio_out}, 0);
      chk(slave_oe == 0, "R1 slave released", slave_oe, 0);
      chk(stat == 1, "R1 status pulled high", stat, 1);
      chk(phy_wr == 0 && phy_rd == 0, "R1 no strobes", {phy_wr, phy_rd}, 0);

      // R2 host control and status
      ctl_wr(3'b011);
      chk({mdc, mdio_oe, mdio_out} == 3'b011, "R2 control bits", {mdc, mdio_oe, mdio_out}, 3'b011);
      chk(stat == 1, "R2 status driven one", stat, 1);
      ctl_wr(3'b010);
      chk(stat == 0, "R2 status driven zero", stat, 0);
      ctl_wr(3'b000);
      chk(stat == 1, "R2 status undriven", stat, 1);
      ctl_wr(3'b100);
      chk(mdc == 1, "R2 clock bit", mdc, 1);

      // Directed frames
      do_write(5'd5, 5'd3, 16'hA5C3, 0);
      do_read(5'd5, 5'd3, 0);
      do_read(5'd6, 5'd3, 0);
      do_write(5'd9, 5'd3, 16'h1234, 0);
      do_read(5'd5, 5'd3, 0);

      // R10 unused operation codes
      for (int k = 0; k < 2; k++) begin
         w0 = wr_cnt;
         r0 = rd_cnt;
         run_frame(32, k == 0 ? 2'b00 : 2'b11, 5'd5, 5'd4, 16'hBEEF, 0, rd);
         chk(wr_cnt == w0 && rd_cnt == r0, "R10 no access", {wr_cnt[15:0], rd_cnt[15:0]}, {w0[15:0], r0[15:0]});
         chk(oe_seen == 0, "R10 no drive", oe_seen, 0);
      end
      do_read(5'd5, 5'd4, 0);

      // R3 short idle run: the write frame must not commit
      w0 = wr_cnt;
      run_frame(31, 2'b01, 5'd5, 5'd7, 16'h0F0F, 0, rd);
      for (int i = 0; i < 8; i++) bit_out(1'b1, 0);
      chk(wr_cnt == w0, "R3 short idle no write", wr_cnt, w0);
      chk(oe_seen == 0, "R3 short idle no drive", oe_seen, 0);
      do_read(5'd5, 5'd7, 0);

      // R9 extra writes that keep the clock level
      do_write(5'd5, 5'd12, 16'h5AA5, 1);
      do_read(5'd5, 5'd12, 1);

      // Random mix
      for (int n = 0; n < 30; n++) begin
         logic [4:0] pa, ra;
         pa = ($urandom % 2 == 0) ? cfg_addr : 5'($urandom);
         ra = 5'($urandom);
         if ($urandom % 2 == 0) do_write(pa, ra, 16'($urandom), ($urandom % 2) == 1);
         else                   do_read(pa, ra, ($urandom % 2) == 1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule